// File: doc/BRIEF.md
# Power-Up First-Page Prefetch Sequencer

This block is the device-side control that fills the page data register with the first page of block 0 as soon as the supply becomes usable. It needs no command or address cycles. A supply-good indication from the voltage detector starts it, and a prefetch-enable pin gates it. A temperature-grade strap can suppress it, because extended-temperature parts lack the function. While the page copy runs, the ready output is held low and a copy request is presented to the array model. The copy ends once two things are true: a minimum cycle count has elapsed, and the array model has answered with a copy-done handshake.

After that, the block is ready. Each read-enable pulse moves a column pointer forward through the page, and the byte at that column, supplied by the array model, is driven onto the I/O output. When no valid page is loaded, the I/O output is held at zero. If prefetch is disabled at power-up, ready rises straight away and the data register is left invalid.

Top module: `pwrup_page_fetch`

## Requirements
- R1: While reset is asserted, and afterwards until the first supply-good rising edge, `rdy` is 0, `copy_req` is 0, `io_out` is 0 and `col_ptr` is 0.
- R2: A rising edge of `supply_ok`, with `prefetch_en`=1 and `ext_temp`=0, starts a copy: `copy_req` is 1 and `rdy` is 0 for at least COPY_CYCLES clock cycles.
- R3: `rdy` stays 0 until `copy_done` has been sampled high during the copy. When the handshake is late, `rdy` rises on the clock edge that follows the first cycle with `copy_done`=1.
- R4: Once ready after a copy, `io_out` equals `arr_byte` for the column on `col_ptr`. `col_ptr` starts at 0 and advances by one at the first clock edge after `re_n` returns high, so the k-th read pulse presents the byte of column k-1.
- R5: `io_out` is 0 whenever no valid page is loaded: while powered down, during the copy, and in the invalid state.
- R6: If `prefetch_en` is 0 at the supply-good rising edge, `rdy` is 1 one clock later, no copy is requested, and read pulses return 0.
- R7: If `ext_temp` is 1 at the supply-good rising edge, the copy is suppressed in the same way as in R6.
- R8: `col_ptr` stops at PAGE_BYTES-1 (2111 by default). Further read pulses keep presenting the last column.
- R9: When `supply_ok` falls, the block returns to the powered-down state with `rdy`=0 one clock later. The next rise starts a new copy, and reading restarts from column 0.
- R10: `prefetch_en` and `ext_temp` are sampled only at the supply-good rising edge. Changing them during the copy does not stop the copy or invalidate the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Supply-good indication from the voltage detector |
| prefetch_en | input | 1 | Enables the power-up page load |
| ext_temp | input | 1 | Strap; 1 marks an extended-temperature grade and suppresses the load |
| re_n | input | 1 | Read enable, active low; the pointer advances at its release |
| copy_done | input | 1 | Page-copy-complete handshake from the array model |
| arr_byte | input | DW | Data register byte at column `col_ptr` |
| rdy | output | 1 | Ready (1) / busy (0) |
| copy_req | output | 1 | High while the page copy is in progress |
| col_ptr | output | clog2(PAGE_BYTES) | Current output column |
| io_out | output | DW | I/O byte; 0 when no valid page is loaded |

## Verification
The power-up sequence is exercised under four gating patterns: prefetch on with a normal grade, prefetch off, the extended-grade strap set, and the pins toggled after the supply edge. Together these separate a real load from the two suppression paths, and show that the gating is sampled once. Two copy-done latencies, one shorter and one longer than the minimum count, show which of the two conditions ends the busy window. A full-page read plus extra pulses checks the byte order and saturation at the last column. A supply drop in the middle of a read checks that the pointer is cleared on restart.

// File: rtl/pwrup_page_fetch.sv
module pwrup_page_fetch #(
  parameter int PAGE_BYTES  = 2112,
  parameter int COPY_CYCLES = 8,
  parameter int DW          = 8,
  localparam int CW = $clog2(PAGE_BYTES),
  localparam int TW = $clog2(COPY_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok,
  input  logic          prefetch_en,
  input  logic          ext_temp,
  input  logic          re_n,
  input  logic          copy_done,
  input  logic [DW-1:0] arr_byte,
  output logic          rdy,
  output logic          copy_req,
  output logic [CW-1:0] col_ptr,
  output logic [DW-1:0] io_out
);
  localparam logic [CW-1:0] COL_LAST = CW'(PAGE_BYTES - 1);
  localparam logic [TW-1:0] CNT_LAST = TW'(COPY_CYCLES - 1);

  typedef enum logic [1:0] {S_OFF, S_COPY, S_VALID, S_INVALID} state_t;

  state_t        state;
  logic          supply_q, re_q, got_done;
  logic [TW-1:0] cnt;

  wire rise     = supply_ok & ~supply_q;
  wire cnt_full = (cnt == CNT_LAST);
  wire re_rel   = ~re_q & re_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_OFF;
      supply_q <= 1'b0;
      re_q     <= 1'b1;
      got_done <= 1'b0;
      cnt      <= '0;
      col_ptr  <= '0;
    end else begin
      supply_q <= supply_ok;
      re_q     <= re_n;
      if (!supply_ok) begin
        state    <= S_OFF;
        got_done <= 1'b0;
        cnt      <= '0;
        col_ptr  <= '0;
      end else begin
        case (state)
          S_OFF: if (rise) begin
            cnt      <= '0;
            got_done <= 1'b0;
            col_ptr  <= '0;
            state    <= (prefetch_en && !ext_temp) ? S_COPY : S_INVALID;
          end
          S_COPY: begin
            if (copy_done) got_done <= 1'b1;
            if (cnt_full && (got_done || copy_done)) state <= S_VALID;
            else if (!cnt_full) cnt <= cnt + 1'b1;
          end
          S_VALID: if (re_rel && col_ptr != COL_LAST) col_ptr <= col_ptr + 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign rdy      = (state == S_VALID) || (state == S_INVALID);
  assign copy_req = (state == S_COPY);
  assign io_out   = (state == S_VALID) ? arr_byte : '0;
endmodule

// File: rtl/pwrup_page_fetch_chk.sv
module pwrup_page_fetch_chk #(
  parameter int PAGE_BYTES = 2112,
  parameter int DW         = 8,
  localparam int CW = $clog2(PAGE_BYTES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_ok,
  input logic          rdy,
  input logic          copy_req,
  input logic [CW-1:0] col_ptr,
  input logic [DW-1:0] io_out
);
  a_r2_busy_in_copy: assert property (@(posedge clk) disable iff (!rst_n)
    copy_req |-> !rdy);

  a_r5_io_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |-> io_out == '0);

  a_r8_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    col_ptr <= CW'(PAGE_BYTES - 1));

  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && $past(rdy)) |-> (col_ptr == $past(col_ptr) || col_ptr == CW'($past(col_ptr) + 1'b1)));

  a_r9_drop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !rdy);
endmodule

bind pwrup_page_fetch pwrup_page_fetch_chk #(.PAGE_BYTES(PAGE_BYTES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .rdy(rdy),
  .copy_req(copy_req), .col_ptr(col_ptr), .io_out(io_out)
);

// File: tb/tb_pwrup_page_fetch.sv
`timescale 1ns/1ps
module tb_pwrup_page_fetch;
  localparam int PAGE = 2112;
  localparam int CC   = 8;
  localparam int CW   = $clog2(PAGE);

  logic clk = 0, rst_n = 0, supply_ok = 0, prefetch_en = 1, ext_temp = 0, re_n = 1;
  logic copy_done, rdy, copy_req;
  logic [7:0] arr_byte, io_out;
  logic [CW-1:0] col_ptr;
  int done_lat = 0;
  int dcnt = 0;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(int k);
    return 8'((k * 37) + (k >> 8) + 5);
  endfunction

  assign arr_byte  = pat(int'(col_ptr));
  assign copy_done = copy_req && (dcnt >= done_lat);
  always_ff @(posedge clk) dcnt <= copy_req ? dcnt + 1 : 0;

  pwrup_page_fetch dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .prefetch_en(prefetch_en),
    .ext_temp(ext_temp), .re_n(re_n), .copy_done(copy_done), .arr_byte(arr_byte),
    .rdy(rdy), .copy_req(copy_req), .col_ptr(col_ptr), .io_out(io_out)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic power_down();
    @(negedge clk) supply_ok = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic power_up();
    @(negedge clk) supply_ok = 1;
  endtask

  task automatic read_byte(output logic [7:0] v);
    @(negedge clk) re_n = 0;
    @(negedge clk) v = io_out;
    re_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_ready_after(int n, string req);
    repeat (n) @(posedge clk);
    @(negedge clk);
    check(rdy == 0 && copy_req == 1, req, rdy, 0);
    check(io_out == 0, "R5", io_out, 0);
    @(posedge clk);
    @(negedge clk);
    check(rdy == 1 && copy_req == 0, req, rdy, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(rdy == 0 && copy_req == 0 && io_out == 0 && col_ptr == 0, "R1", rdy, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(rdy == 0 && copy_req == 0 && io_out == 0, "R1", rdy, 0);
  endtask

  task automatic t_normal();
    logic [7:0] v;
    done_lat = 0;
    power_up();
    wait_ready_after(CC, "R2");
    for (int k = 0; k < 6; k++) begin
      read_byte(v);
      check(v == pat(k), "R4", v, pat(k));
    end
  endtask

  task automatic t_late_done();
    power_down();
    done_lat = 20;
    power_up();
    wait_ready_after(21, "R3");
    done_lat = 0;
  endtask

  task automatic t_suppressed(bit pf, bit et, string req);
    logic [7:0] v;
    power_down();
    prefetch_en = pf;
    ext_temp = et;
    power_up();
    @(posedge clk);
    @(negedge clk);
    check(rdy == 1 && copy_req == 0, req, rdy, 1);
    read_byte(v);
    check(v == 0, req, v, 0);
    check(copy_req == 0, req, copy_req, 0);
    prefetch_en = 1;
    ext_temp = 0;
  endtask

  task automatic t_saturate();
    logic [7:0] v;
    power_down();
    power_up();
    wait_ready_after(CC, "R2");
    for (int k = 0; k < PAGE + 3; k++) begin
      read_byte(v);
      if (k == PAGE - 2 || k >= PAGE - 1) begin
        int e = (k >= PAGE - 1) ? PAGE - 1 : k;
        check(v == pat(e), "R8", v, pat(e));
      end
    end
    check(col_ptr == CW'(PAGE - 1), "R8", col_ptr, PAGE - 1);
  endtask

  task automatic t_drop();
    logic [7:0] v;
    power_down();
    power_up();
    wait_ready_after(CC, "R9");
    for (int k = 0; k < 4; k++) read_byte(v);
    @(negedge clk) supply_ok = 0;
    @(posedge clk);
    @(negedge clk);
    check(rdy == 0 && io_out == 0, "R9", rdy, 0);
    power_up();
    wait_ready_after(CC, "R9");
    read_byte(v);
    check(v == pat(0), "R9", v, pat(0));
  endtask

  task automatic t_pin_change();
    logic [7:0] v;
    power_down();
    power_up();
    @(negedge clk);
    prefetch_en = 0;
    ext_temp = 1;
    wait_ready_after(CC - 1, "R10");
    read_byte(v);
    check(v == pat(0), "R10", v, pat(0));
    prefetch_en = 1;
    ext_temp = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_normal();
    t_late_done();
    t_suppressed(1'b0, 1'b0, "R6");
    t_suppressed(1'b1, 1'b1, "R7");
    t_saturate();
    t_drop();
    t_pin_change();
    summary();
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule